// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This block holds the interrupt state for the host side of a network controller. Single-cycle event pulses come in from the command engine, the receive engine, the PHY management engine and the pause-frame logic. Each pulse sets a sticky bit in a byte-wide status register. The host reads that register and clears bits by writing ones to them. A second byte holds the masks: six per-source mask bits, a global mask and a software-trigger bit. The block combines the status and the masks into one level-sensitive interrupt line.

The host reaches both bytes through a small read/write port. A select input chooses the status byte or the mask byte. A configuration input sets how the command engine's "not active" condition is reported. With the input set, only entry to idle raises the condition. With the input clear, entry to idle or to suspended raises it.

Top module: `nic_irq_unit`

## Requirements
- R1: After reset the status byte reads 0x00, the mask byte reads 0x01 (global mask set, all per-source masks clear) and `irq` is low.
- R2: A one-cycle pulse on an event input sets its status bit, visible from the next clock edge. The bit positions are: command-done 7, frame-received 6, command-not-active 5, receive-not-ready 4, management-done 3, software 2, pause 0.
- R3: Writing the status byte (`reg_sel`=0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event arrives in the same cycle as a write-1 acknowledge of its bit, the bit stays set.
- R5: With `cfg_idle_only`=1, only `ev_cu_idle` sets bit 5. With `cfg_idle_only`=0, either `ev_cu_idle` or `ev_cu_suspend` sets it.
- R6: The mask byte (`reg_sel`=1) stores bits 7..2 as the per-source masks and bit 0 as the global mask, and reads them back. Bit 1 always reads 0.
- R7: Writing the mask byte with bit 1 set raises the software status bit (bit 2). The bit is still clear one edge after the write and is set from the second edge after the write.
- R8: Status bit 1 is reserved and always reads 0.
- R9: `irq` is high exactly when the global mask is clear and some status bit is set whose mask is clear. The masks pair up as follows: mask bits 7,6,5,4,3 cover status bits 7,6,5,4,3, and mask bit 2 covers status bit 0. Status bit 2 is masked only by the global mask.
- R10: `irq` is a level. It stays high while its cause is still pending and drops once the causing bits are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the status byte, 1 selects the mask byte |
| reg_wr | input | 1 | Write strobe for the selected byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte |
| ev_cmd_done | input | 1 | Command finished with interrupt requested |
| ev_frame_rx | input | 1 | Frame received |
| ev_cu_idle | input | 1 | Command engine entered idle |
| ev_cu_suspend | input | 1 | Command engine entered suspended |
| ev_ru_not_ready | input | 1 | Receive engine left the ready state |
| ev_mgmt_done | input | 1 | PHY management cycle finished |
| ev_pause | input | 1 | Pause-frame event |
| cfg_idle_only | input | 1 | 1: only idle raises not-active; 0: idle or suspended |
| irq | output | 1 | Level interrupt request |

## Verification
The event inputs are pulsed one at a time while the global mask is set. Each status bit must appear at its own position while `irq` stays low, which tells the bit map apart from the masking. Mask patterns then open one source at a time, including the pause source whose mask sits at a different position. This separates a correct mask-to-status pairing from a straight bitwise pairing. An event pulse landing in the same cycle as a write-1 acknowledge tells set priority apart from clear priority. Suspend pulses under both settings of the configuration input separate the two reporting modes. A software trigger written with every source masked shows the two-edge latency, shows that the trigger bit reads back as 0, and shows that the software bit can be masked only by the global mask.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned SRC_MSK = 6;

    localparam int unsigned B_CMD  = 7;
    localparam int unsigned B_FRM  = 6;
    localparam int unsigned B_CNA  = 5;
    localparam int unsigned B_RNR  = 4;
    localparam int unsigned B_MGT  = 3;
    localparam int unsigned B_SW   = 2;
    localparam int unsigned B_RSV  = 1;
    localparam int unsigned B_PAU  = 0;

    localparam int unsigned M_GLB  = 0;
    localparam int unsigned M_SWT  = 1;

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } stat_st_t;

    typedef struct packed {
        logic [SRC_MSK-1:0] src;
        logic               glb;
        logic               swt;
    } mask_st_t;
endpackage

// File: rtl/nic_irq_evmap.sv
module nic_irq_evmap
    import nic_irq_pkg::*;
(
    input  logic             ev_cmd_done,
    input  logic             ev_frame_rx,
    input  logic             ev_cu_idle,
    input  logic             ev_cu_suspend,
    input  logic             ev_ru_not_ready,
    input  logic             ev_mgmt_done,
    input  logic             ev_pause,
    input  logic             sw_pulse,
    input  logic             cfg_idle_only,
    output logic [REG_W-1:0] set_vec
);
    logic cna_raise;

    always_comb begin
        cna_raise      = ev_cu_idle | (ev_cu_suspend & ~cfg_idle_only);
        set_vec        = '0;
        set_vec[B_CMD] = ev_cmd_done;
        set_vec[B_FRM] = ev_frame_rx;
        set_vec[B_CNA] = cna_raise;
        set_vec[B_RNR] = ev_ru_not_ready;
        set_vec[B_MGT] = ev_mgmt_done;
        set_vec[B_SW]  = sw_pulse;
        set_vec[B_PAU] = ev_pause;
    end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] ack_vec,
    output logic [REG_W-1:0] status
);
    stat_st_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.bits       = (st_q.bits & ~ack_vec) | set_vec;
        st_d.bits[B_RSV] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;

    // R8: reserved bit never reads as set
    a_r8_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_RSV] == 1'b0);

    // R3: a set bit survives unless its acknowledge was written
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status | $past(ack_vec)) & $past(status)) == $past(status)));

    // R4: an arriving event wins over a same-cycle acknowledge
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask
    import nic_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rd_val,
    output logic [REG_W-1:0] per_bit_mask,
    output logic             glb_mask,
    output logic             sw_pulse
);
    mask_st_t mk_d, mk_q;

    always_comb begin
        mk_d     = mk_q;
        mk_d.swt = 1'b0;
        if (wr_en) begin
            mk_d.src = wdata[REG_W-1:REG_W-SRC_MSK];
            mk_d.glb = wdata[M_GLB];
            mk_d.swt = wdata[M_SWT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mk_q.src <= '0;
            mk_q.glb <= 1'b1;
            mk_q.swt <= 1'b0;
        end else begin
            mk_q <= mk_d;
        end
    end

    always_comb begin
        rd_val                         = '0;
        rd_val[REG_W-1:REG_W-SRC_MSK]  = mk_q.src;
        rd_val[M_GLB]                  = mk_q.glb;
        per_bit_mask                   = '0;
        per_bit_mask[B_CMD]            = mk_q.src[5];
        per_bit_mask[B_FRM]            = mk_q.src[4];
        per_bit_mask[B_CNA]            = mk_q.src[3];
        per_bit_mask[B_RNR]            = mk_q.src[2];
        per_bit_mask[B_MGT]            = mk_q.src[1];
        per_bit_mask[B_PAU]            = mk_q.src[0];
        per_bit_mask[B_RSV]            = 1'b1;
    end

    assign glb_mask = mk_q.glb;
    assign sw_pulse = mk_q.swt;

    // R7: the trigger lasts one cycle unless rewritten
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pulse && !(wr_en && wdata[M_SWT])) |=> !sw_pulse);
endmodule

// File: rtl/nic_irq_combine.sv
module nic_irq_combine
    import nic_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] per_bit_mask,
    input  logic             glb_mask,
    output logic             irq
);
    logic [REG_W-1:0] live;

    always_comb begin
        live = status & ~per_bit_mask;
        irq  = ~glb_mask & (|live);
    end

    // R9: global mask silences the line
    a_r9_glb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        glb_mask |-> !irq);

    // R10: nothing pending means no request
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
    import nic_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_cmd_done,
    input  logic       ev_frame_rx,
    input  logic       ev_cu_idle,
    input  logic       ev_cu_suspend,
    input  logic       ev_ru_not_ready,
    input  logic       ev_mgmt_done,
    input  logic       ev_pause,
    input  logic       cfg_idle_only,
    output logic       irq
);
    logic [REG_W-1:0] set_vec, ack_vec, status, mask_rd, pb_mask;
    logic             glb_mask, sw_pulse, mask_wr;

    assign ack_vec = (reg_wr && !reg_sel) ? reg_wdata : '0;
    assign mask_wr = reg_wr && reg_sel;

    nic_irq_evmap u_map (
        .ev_cmd_done(ev_cmd_done), .ev_frame_rx(ev_frame_rx),
        .ev_cu_idle(ev_cu_idle), .ev_cu_suspend(ev_cu_suspend),
        .ev_ru_not_ready(ev_ru_not_ready), .ev_mgmt_done(ev_mgmt_done),
        .ev_pause(ev_pause), .sw_pulse(sw_pulse),
        .cfg_idle_only(cfg_idle_only), .set_vec(set_vec));

    nic_irq_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .ack_vec(ack_vec), .status(status));

    nic_irq_mask u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(reg_wdata),
        .rd_val(mask_rd), .per_bit_mask(pb_mask), .glb_mask(glb_mask),
        .sw_pulse(sw_pulse));

    nic_irq_combine u_comb (
        .clk(clk), .rst_n(rst_n), .status(status), .per_bit_mask(pb_mask),
        .glb_mask(glb_mask), .irq(irq));

    assign reg_rdata = reg_sel ? mask_rd : status;

    // R5: suspend reports not-active when idle-only is off
    a_r5_suspend_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cu_suspend && !cfg_idle_only) |=> status[B_CNA]);

    // R7: software trigger lands on status two edges after the write
    a_r7_sw_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata[M_SWT]) |=> ##1 status[B_SW]);
endmodule

// File: tb/sim_nic_irq_unit.sv
module sim_nic_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ev_cmd_done = 0, ev_frame_rx = 0, ev_cu_idle = 0, ev_cu_suspend = 0;
    logic       ev_ru_not_ready = 0, ev_mgmt_done = 0, ev_pause = 0;
    logic       cfg_idle_only = 1'b1;
    logic       irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    nic_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_cmd_done(ev_cmd_done), .ev_frame_rx(ev_frame_rx),
        .ev_cu_idle(ev_cu_idle), .ev_cu_suspend(ev_cu_suspend),
        .ev_ru_not_ready(ev_ru_not_ready), .ev_mgmt_done(ev_mgmt_done),
        .ev_pause(ev_pause), .cfg_idle_only(cfg_idle_only), .irq(irq));

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = it.is_irq ? {7'd0, irq} : reg_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input bit sel, input logic [7:0] exp, input string tag, input bit wait_edge);
        if (wait_edge) @(negedge clk);
        reg_sel = sel;
        reg_wr  = 1'b0;
        sb.push_back('{1'b0, exp, tag});
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        @(negedge clk);
        reg_wr = 1'b0;
        sb.push_back('{1'b1, {7'd0, exp}, tag});
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_cmd_done = 1;     1: ev_frame_rx = 1;   2: ev_cu_idle = 1;
            3: ev_cu_suspend = 1;   4: ev_ru_not_ready = 1;
            5: ev_mgmt_done = 1;    default: ev_pause = 1;
        endcase
        @(negedge clk);
        {ev_cmd_done, ev_frame_rx, ev_cu_idle, ev_cu_suspend,
         ev_ru_not_ready, ev_mgmt_done, ev_pause} = '0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 8'h00, "R1 status after reset", 1);
        chk(1, 8'h01, "R1 mask after reset", 1);
        chk_irq(0, "R1 irq after reset");

        // R2 bit map, global mask still set
        pulse(0); chk(0, 8'h80, "R2 cmd_done bit7", 1);
        pulse(1); chk(0, 8'hC0, "R2 frame bit6", 1);
        pulse(2); chk(0, 8'hE0, "R2 idle bit5", 1);
        pulse(4); chk(0, 8'hF0, "R2 rnr bit4", 1);
        pulse(5); chk(0, 8'hF8, "R2 mgmt bit3", 1);
        pulse(6); chk(0, 8'hF9, "R2 pause bit0 / R8 bit1 low", 1);
        chk_irq(0, "R9 global mask holds irq low");

        // R3 write-1-to-clear
        wr(0, 8'h81); chk(0, 8'h78, "R3 ack 0x81", 1);
        wr(0, 8'h00); chk(0, 8'h78, "R3 zero write no effect", 1);

        // R9 / R10 masking and level
        wr(1, 8'h00); chk_irq(1, "R9 all unmasked");
        repeat (3) @(negedge clk);
        chk_irq(1, "R10 level held");
        wr(1, 8'hFC); chk_irq(0, "R9 all sources masked");
        wr(1, 8'hBC); chk_irq(1, "R9 frame unmasked");
        chk(1, 8'hBC, "R6 mask readback", 1);
        wr(0, 8'hFF); chk_irq(0, "R10 drops after ack");
        chk(0, 8'h00, "R3 ack all", 1);

        // R4 set beats same-cycle acknowledge
        pulse(1); pulse(4);
        @(negedge clk);
        reg_sel = 0; reg_wr = 1; reg_wdata = 8'h50; ev_frame_rx = 1;
        @(negedge clk);
        reg_wr = 0; ev_frame_rx = 0;
        chk(0, 8'h40, "R4 frame kept, rnr cleared", 0);
        wr(0, 8'hFF);

        // R5 not-active reporting modes
        cfg_idle_only = 1;
        pulse(3); chk(0, 8'h00, "R5 suspend ignored in idle-only", 1);
        pulse(2); chk(0, 8'h20, "R5 idle reported in idle-only", 1);
        wr(0, 8'hFF);
        cfg_idle_only = 0;
        pulse(3); chk(0, 8'h20, "R5 suspend reported", 1);
        wr(0, 8'hFF);

        // R7 software trigger, R6 readback, R9 software source
        wr(1, 8'hFE);
        chk(0, 8'h00, "R7 sw bit not yet set", 0);
        chk(0, 8'h04, "R7 sw bit set", 1);
        chk_irq(1, "R9 sw only global-maskable");
        chk(1, 8'hFC, "R6 trigger bit reads 0", 1);
        wr(1, 8'hFD); chk_irq(0, "R9 global mask over sw");
        chk(0, 8'h04, "R7 single trigger only", 1);
        wr(0, 8'hFF);

        // R9 pause mask sits at mask bit 2
        wr(1, 8'hF8);
        pulse(6); chk_irq(1, "R9 pause unmasked by bit2");
        wr(1, 8'hFC); chk_irq(0, "R9 pause masked by bit2");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule